// File: doc/BRIEF.md
# Delay-Slot Annulment Controller

This block sits at the branch-resolution point of an in-order pipeline with architectural delay slots. When a branch resolves, the block combines the branch outcome with a two-bit annul option carried by that particular branch. It then decides whether the delay-slot instructions that follow the branch may commit or must be squashed. For a taken branch it also issues a fetch redirect to the resolved target. The redirect carries the number of slot instructions still to be fetched before the target, so slot instructions are never fetched twice. Along with the redirect it raises a flush of the younger fall-through fetches.

All results are registered. They appear as a single-cycle pulse the cycle after the branch resolves, and they are frozen while the pipeline is stalled. The consumer clears the valid bit of each slot instruction whose kill bit is set before that instruction reaches writeback, so a squashed slot writes no register, no memory and no condition codes. A branch that lands in a slot which is being annulled is itself dead, and the block ignores it. The number of delay slots and the address width are parameters.

Top module: `slot_annul_ctrl`

## Requirements
- R1: Annul option 2'b00 (none) never sets any kill bit, whether or not the branch is taken.
- R2: Annul option 2'b01 (squash on fall-through) sets every kill bit when the branch is not taken and none when it is taken.
- R3: Annul option 2'b10 (squash on taken) sets every kill bit when the branch is taken and none when it is not taken.
- R4: Annul option 2'b11 (squash always) sets every kill bit whatever the outcome.
- R5: The annul option is taken from each branch individually, so back-to-back branches with different options each get their own result.
- R6: A taken branch raises `redir_valid` and `flush_young` with `redir_target` equal to the resolved target and `redir_skip` = NSLOT - min(`slots_inflight`, NSLOT). A not-taken branch raises neither.
- R7: Results appear in the cycle after the clock edge at which the branch is accepted. Without a stall they last exactly one cycle, and a branch that asks for no kill and no redirect produces no output at all.
- R8: While `stall` is high, pending results are held unchanged until the first edge with `stall` low, and `br_valid` is not accepted.
- R9: After an accepted branch that squashes its slots, a `br_valid` seen in any of the next NSLOT unstalled cycles is ignored: no kill, redirect or flush comes from it.
- R10: With `br_valid` low, no kill, redirect or flush is produced, whatever the other branch inputs are.
- R11: A synchronous active-low reset clears pending results and the ignore window, so a branch in the first cycle after reset is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall | input | 1 | Pipeline stall; freezes results and blocks acceptance |
| br_valid | input | 1 | A branch resolves this cycle |
| br_taken | input | 1 | Resolved outcome, 1 = taken |
| br_target | input | ADDR_W (32) | Resolved target address |
| br_annul | input | 2 | Annul option of this branch (00 none, 01 fall-through, 10 taken, 11 always) |
| slots_inflight | input | CNT_W (2) | Slot instructions already fetched behind the branch |
| kill_mask | output | NSLOT (2) | Bit i squashes slot i (0 = oldest) |
| redir_valid | output | 1 | Fetch redirect strobe |
| redir_target | output | ADDR_W (32) | Redirect address |
| redir_skip | output | CNT_W (2) | Slot instructions still to fetch before the target |
| flush_young | output | 1 | Discard fall-through fetches younger than the slots |

## Verification
The two functions that can collide are the stall hold of an earlier result and the arrival of a new branch. The bench raises `stall` in the cycle a result appears and keeps `br_valid` high throughout the stall. The scoreboard then requires the result to stay identical until release, and requires that no extra item appears for the stalled branch. A second collision is between the ignore window of an annulling branch and a new branch resolving at once. Branches are driven in the cycles right after an always-annul branch. Any output from them finds an empty expected queue and is reported, while the first branch after the window must still be honoured.

// File: rtl/sac_pkg.sv
// Package: shared encodings for the delay-slot annulment controller.
// Assumes the annul option is a 2-bit field decoded from the branch encoding.
package sac_pkg;

    typedef enum logic [1:0] {
        ANN_NONE     = 2'b00,
        ANN_ON_FALL  = 2'b01,
        ANN_ON_TAKEN = 2'b10,
        ANN_ALWAYS   = 2'b11
    } annul_mode_e;

    // Returns 1 when the slot instructions of a branch must be squashed.
    function automatic logic slot_squash(annul_mode_e mode, logic taken);
        unique case (mode)
            ANN_NONE:     return 1'b0;
            ANN_ON_FALL:  return !taken;
            ANN_ON_TAKEN: return taken;
            default:      return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/sac_annul_decide.sv
// Module: sac_annul_decide
// Purely combinational. It turns the annul option and the outcome of the
// resolving branch into a per-slot kill mask. It also works out how many
// slot instructions remain to be fetched before a redirect may take effect.
// Assumes slots_inflight counts slots already fetched and may exceed NSLOT
// only through a consumer error, in which case it is saturated.
module sac_annul_decide
    import sac_pkg::*;
#(
    parameter int NSLOT = 2,
    parameter int CNT_W = $clog2(NSLOT + 1)
) (
    input  annul_mode_e        mode,
    input  logic               taken,
    input  logic [CNT_W-1:0]   slots_inflight,
    output logic               squash,
    output logic [NSLOT-1:0]   kill_mask,
    output logic [CNT_W-1:0]   skip_cnt
);

    localparam logic [CNT_W-1:0] NSLOT_C = CNT_W'(NSLOT);

    logic [CNT_W-1:0] fetched_sat;

    // Decide squash for this branch from its own option and outcome.
    always_comb squash = slot_squash(mode, taken);

    // One kill bit per slot; every slot of the branch shares the decision.
    for (genvar gi = 0; gi < NSLOT; gi++) begin : g_slot
        assign kill_mask[gi] = squash;
    end

    // Saturate the in-flight count and derive the slots still to fetch.
    always_comb begin
        fetched_sat = (slots_inflight > NSLOT_C) ? NSLOT_C : slots_inflight;
        skip_cnt    = NSLOT_C - fetched_sat;
    end

endmodule

// File: rtl/sac_shadow.sv
// Module: sac_shadow
// Tracks the window in which the slots of an annulling branch pass the
// resolve point. A branch seen there sits in a dead slot and is refused.
// Assumes one instruction reaches the resolve point per unstalled cycle.
module sac_shadow #(
    parameter int NSLOT = 2,
    parameter int CNT_W = $clog2(NSLOT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stall,
    input  logic br_valid,
    input  logic squash,
    output logic accept,
    output logic busy
);

    localparam logic [CNT_W-1:0] NSLOT_C = CNT_W'(NSLOT);

    logic [CNT_W-1:0] dead_left;

    // Window is open while dead slot instructions remain.
    always_comb busy = (dead_left != '0);

    // Accept a branch only if the pipeline moves and it is not in a dead slot.
    always_comb accept = br_valid && !stall && !busy;

    // Load the window on an annulling branch, count it down as the pipe moves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dead_left <= '0;
        end else if (accept) begin
            dead_left <= squash ? NSLOT_C : '0;
        end else if (!stall && busy) begin
            dead_left <= dead_left - 1'b1;
        end
    end

endmodule

// File: rtl/sac_out_stage.sv
// Module: sac_out_stage
// Output register for kill, redirect and flush. It loads on an accepted
// branch that needs an action and drops after one unstalled cycle. It holds
// its value for as long as stall is high.
// Assumes load is never raised while stall is high.
module sac_out_stage #(
    parameter int ADDR_W = 32,
    parameter int NSLOT  = 2,
    parameter int CNT_W  = $clog2(NSLOT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              load,
    input  logic              taken,
    input  logic [ADDR_W-1:0] target,
    input  logic [NSLOT-1:0]  kill_in,
    input  logic [CNT_W-1:0]  skip_in,
    output logic [NSLOT-1:0]  kill_mask,
    output logic              redir_valid,
    output logic [ADDR_W-1:0] redir_target,
    output logic [CNT_W-1:0]  redir_skip,
    output logic              flush_young
);

    logic              vld_q;
    logic              taken_q;
    logic [ADDR_W-1:0] tgt_q;
    logic [NSLOT-1:0]  kill_q;
    logic [CNT_W-1:0]  skip_q;

    // Hold-or-retire result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q   <= 1'b0;
            taken_q <= 1'b0;
            tgt_q   <= '0;
            kill_q  <= '0;
            skip_q  <= '0;
        end else if (load) begin
            vld_q   <= 1'b1;
            taken_q <= taken;
            tgt_q   <= target;
            kill_q  <= kill_in;
            skip_q  <= skip_in;
        end else if (vld_q && !stall) begin
            vld_q   <= 1'b0;
            taken_q <= 1'b0;
            kill_q  <= '0;
        end
    end

    // Gate the stored result onto the ports.
    always_comb begin
        kill_mask    = vld_q ? kill_q : '0;
        redir_valid  = vld_q && taken_q;
        flush_young  = vld_q && taken_q;
        redir_target = tgt_q;
        redir_skip   = skip_q;
    end

    AST_HOLD_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && stall) |=> (vld_q && $stable(kill_mask) && $stable(redir_valid)
                              && $stable(redir_target) && $stable(redir_skip))); // R8

    AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && !stall && !load) |=> !vld_q); // R7

endmodule

// File: rtl/slot_annul_ctrl.sv
// Module: slot_annul_ctrl (top)
// Resolves the delay-slot annul option of each branch against its outcome.
// It drives a registered per-slot kill mask, a fetch redirect with the
// count of slots still to fetch, and a flush of younger fall-through
// fetches. Assumes the resolve stage presents at most one branch per cycle
// and that condition and target evaluation are done upstream.
module slot_annul_ctrl
    import sac_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NSLOT  = 2,
    parameter int CNT_W  = $clog2(NSLOT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              br_valid,
    input  logic              br_taken,
    input  logic [ADDR_W-1:0] br_target,
    input  logic [1:0]        br_annul,
    input  logic [CNT_W-1:0]  slots_inflight,
    output logic [NSLOT-1:0]  kill_mask,
    output logic              redir_valid,
    output logic [ADDR_W-1:0] redir_target,
    output logic [CNT_W-1:0]  redir_skip,
    output logic              flush_young
);

    logic             squash;
    logic [NSLOT-1:0] kill_next;
    logic [CNT_W-1:0] skip_next;
    logic             accept;
    logic             dead_busy;
    logic             load;

    sac_annul_decide #(.NSLOT(NSLOT), .CNT_W(CNT_W)) u_decide (
        .mode           (annul_mode_e'(br_annul)),
        .taken          (br_taken),
        .slots_inflight (slots_inflight),
        .squash         (squash),
        .kill_mask      (kill_next),
        .skip_cnt       (skip_next)
    );

    sac_shadow #(.NSLOT(NSLOT), .CNT_W(CNT_W)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .stall    (stall),
        .br_valid (br_valid),
        .squash   (squash),
        .accept   (accept),
        .busy     (dead_busy)
    );

    // Only branches that squash or redirect need a result slot.
    always_comb load = accept && (squash || br_taken);

    sac_out_stage #(.ADDR_W(ADDR_W), .NSLOT(NSLOT), .CNT_W(CNT_W)) u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .stall        (stall),
        .load         (load),
        .taken        (br_taken),
        .target       (br_target),
        .kill_in      (kill_next),
        .skip_in      (skip_next),
        .kill_mask    (kill_mask),
        .redir_valid  (redir_valid),
        .redir_target (redir_target),
        .redir_skip   (redir_skip),
        .flush_young  (flush_young)
    );

    AST_NONE_KEEPS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && br_annul == 2'b00) |=> (kill_mask == '0)); // R1

    AST_FALL_SQUASHES: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && br_annul == 2'b01 && !br_taken) |=> (&kill_mask)); // R2

    AST_ALWAYS_SQUASHES: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && br_annul == 2'b11) |=> (&kill_mask)); // R4

    AST_NO_REDIR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !br_taken) |=> !redir_valid); // R6

    AST_DEAD_SLOT_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (dead_busy && br_valid && !stall) |=> !(redir_valid || flush_young || (|kill_mask))); // R9

    AST_NO_REDIR_UNLESS_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(redir_valid) |-> $past(br_valid)); // R10

endmodule

// File: tb/slot_annul_ctrl_bench.sv
`timescale 1ns/100ps
module slot_annul_ctrl_bench;

    localparam int ADDR_W = 32;
    localparam int NSLOT  = 2;
    localparam int CNT_W  = $clog2(NSLOT + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              stall = 1'b0;
    logic              br_valid = 1'b0;
    logic              br_taken = 1'b0;
    logic [ADDR_W-1:0] br_target = '0;
    logic [1:0]        br_annul = 2'b00;
    logic [CNT_W-1:0]  slots_inflight = '0;
    logic [NSLOT-1:0]  kill_mask;
    logic              redir_valid;
    logic [ADDR_W-1:0] redir_target;
    logic [CNT_W-1:0]  redir_skip;
    logic              flush_young;

    slot_annul_ctrl #(.ADDR_W(ADDR_W), .NSLOT(NSLOT)) u_slot_annul_ctrl (
        .clk(clk), .rst_n(rst_n), .stall(stall), .br_valid(br_valid),
        .br_taken(br_taken), .br_target(br_target), .br_annul(br_annul),
        .slots_inflight(slots_inflight), .kill_mask(kill_mask),
        .redir_valid(redir_valid), .redir_target(redir_target),
        .redir_skip(redir_skip), .flush_young(flush_young)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic              taken;
        logic [ADDR_W-1:0] tgt;
        logic [NSLOT-1:0]  kill;
        logic [CNT_W-1:0]  skip;
        string             tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   dead_left = 0;
    bit   done = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit model_squash(input logic [1:0] m, input logic tk);
        case (m)
            2'b00:   return 1'b0;
            2'b01:   return !tk;
            2'b10:   return tk;
            default: return 1'b1;
        endcase
    endfunction

    // Driver: applies one cycle of inputs and queues the expected result.
    task automatic step(input bit v, input bit tk, input logic [ADDR_W-1:0] tgt,
                        input logic [1:0] m, input int infl, input bit st, input string tag);
        bit   acc;
        bit   sq;
        int   fs;
        exp_t e;
        @(negedge clk);
        br_valid = v; br_taken = tk; br_target = tgt; br_annul = m;
        slots_inflight = CNT_W'(infl); stall = st;
        acc = v && !st && (dead_left == 0);
        sq  = model_squash(m, tk);
        if (acc && (sq || tk)) begin
            fs = (infl > NSLOT) ? NSLOT : infl;
            e.taken = tk; e.tgt = tgt; e.kill = sq ? '1 : '0;
            e.skip = CNT_W'(NSLOT - fs); e.tag = tag;
            exp_q.push_back(e);
        end
        if (acc) dead_left = sq ? NSLOT : 0;
        else if (!st && dead_left > 0) dead_left--;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, '0, 2'b00, 0, 0, "idle");
    endtask

    task automatic do_reset(input int n);
        @(negedge clk);
        rst_n = 1'b0; br_valid = 1'b0; stall = 1'b0;
        repeat (n) @(negedge clk);
        exp_q.delete();
        dead_left = 0;
        chk(kill_mask == '0 && !redir_valid && !flush_young, "R11 reset clears outputs",
            {kill_mask, redir_valid, flush_young}, 0);
        rst_n = 1'b1;
    endtask

    // Monitor: compares outputs against the scoreboard after every edge.
    initial begin
        bit prev_act = 0;
        bit act;
        forever begin
            @(posedge clk);
            #1;
            if (!rst_n) begin
                prev_act = 0;
            end else begin
                act = redir_valid || flush_young || (kill_mask != '0);
                if (!stall && prev_act && exp_q.size() > 0) void'(exp_q.pop_front());
                if (act) begin
                    if (exp_q.size() == 0) begin
                        chk(0, "R7/R9/R10 unexpected output", {kill_mask, redir_valid}, 0);
                    end else begin
                        chk(kill_mask == exp_q[0].kill, {exp_q[0].tag, " kill"}, kill_mask, exp_q[0].kill);
                        chk(redir_valid == exp_q[0].taken && flush_young == exp_q[0].taken,
                            {exp_q[0].tag, " R6 redirect/flush"}, {redir_valid, flush_young},
                            {exp_q[0].taken, exp_q[0].taken});
                        if (exp_q[0].taken) begin
                            chk(redir_target == exp_q[0].tgt, {exp_q[0].tag, " R6 target"}, redir_target, exp_q[0].tgt);
                            chk(redir_skip == exp_q[0].skip, {exp_q[0].tag, " R6 skip"}, redir_skip, exp_q[0].skip);
                        end
                    end
                end else if (stall && prev_act) begin
                    chk(0, "R8 result dropped during stall", 0, 1);
                end
                prev_act = act;
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(5ns * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset(3);
        idle(2);
        // R1: no annulment, both outcomes
        step(1, 1, 32'h0000_1000, 2'b00, 0, 0, "R1 none/taken");
        idle(2);
        step(1, 0, 32'h0000_1004, 2'b00, 1, 0, "R1 none/fall");
        idle(2);
        // R2: squash on fall-through
        step(1, 0, 32'h0000_2000, 2'b01, 2, 0, "R2 fall/fall");
        idle(3);
        step(1, 1, 32'h0000_2040, 2'b01, 1, 0, "R2 fall/taken");
        idle(2);
        // R3: squash on taken
        step(1, 1, 32'h0000_3000, 2'b10, 0, 0, "R3 taken/taken");
        idle(3);
        step(1, 0, 32'h0000_3080, 2'b10, 2, 0, "R3 taken/fall");
        idle(2);
        // R4: squash always
        step(1, 1, 32'hDEAD_BEE0, 2'b11, 3, 0, "R4 always/taken");
        idle(3);
        step(1, 0, 32'h0000_4000, 2'b11, 0, 0, "R4 always/fall");
        idle(3);
        // R5/R7: back-to-back branches with their own options
        step(1, 1, 32'h0000_5000, 2'b00, 0, 0, "R5 first none");
        step(1, 1, 32'h0000_5100, 2'b01, 1, 0, "R5 second fall-opt");
        step(1, 1, 32'h0000_5200, 2'b00, 2, 0, "R5 third none");
        idle(2);
        // R9: branches in dead slots after an always-annul branch
        step(1, 0, 32'h0000_6000, 2'b11, 0, 0, "R9 annulling branch");
        step(1, 1, 32'h0000_6100, 2'b00, 0, 0, "R9 dead slot 0");
        step(1, 1, 32'h0000_6200, 2'b11, 0, 0, "R9 dead slot 1");
        step(1, 1, 32'h0000_6300, 2'b00, 1, 0, "R9 first live branch");
        idle(2);
        // R9 with a stall inside the window: window does not shrink
        step(1, 1, 32'h0000_6400, 2'b10, 0, 0, "R9 annul before stall");
        step(1, 1, 32'h0000_6500, 2'b00, 0, 1, "R8 stall in window");
        step(1, 1, 32'h0000_6600, 2'b00, 0, 0, "R9 dead after stall");
        step(1, 1, 32'h0000_6700, 2'b00, 0, 0, "R9 dead after stall 2");
        step(1, 1, 32'h0000_6800, 2'b00, 2, 0, "R9 live after stall");
        idle(2);
        // R8: hold under stall, branch refused while stalled
        step(1, 1, 32'h0000_7000, 2'b01, 1, 0, "R8 held branch");
        step(1, 1, 32'h0000_7100, 2'b11, 0, 1, "R8 refused while stalled");
        step(1, 0, 32'h0000_7200, 2'b11, 0, 1, "R8 refused while stalled 2");
        step(1, 1, 32'h0000_7300, 2'b01, 0, 1, "R8 refused while stalled 3");
        step(1, 1, 32'h0000_7400, 2'b00, 2, 0, "R8 accepted on release");
        idle(3);
        // R10: invalid branch with every other input active
        step(0, 1, 32'h0000_8000, 2'b11, 2, 0, "R10 invalid");
        step(0, 0, 32'h0000_8100, 2'b01, 0, 0, "R10 invalid 2");
        idle(2);
        // R11: reset while a result is held and a window is open
        step(1, 1, 32'h0000_9000, 2'b11, 0, 0, "R11 before reset");
        step(0, 0, '0, 2'b00, 0, 1, "R11 stall");
        do_reset(2);
        step(1, 1, 32'h0000_9100, 2'b00, 0, 0, "R11 first after reset");
        idle(3);
        @(negedge clk);
        chk(exp_q.size() == 0, "R7 all expected results seen", exp_q.size(), 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule